// File: doc/BRIEF.md
# Byte-wide table-driven CRC-32 engine

This block folds a stream of bytes into a 32-bit cyclic redundancy check, consuming one byte per accepted handshake. Each byte is merged into the running remainder, and the bits that drop out of the top of the shifted remainder are cancelled by a precomputed correction word. The correction words are produced during elaboration by a constant function that runs the plain bit-serial division for every index, so no table contents are written out and no file is read.

A parameter picks between a 256-entry table, which advances a whole byte in one clock, and a 16-entry table used twice per byte, which needs two clocks per byte and holds off the producer on the second one. A second parameter picks the bit order: reflected (least significant bit first, the common serial-link convention) or straight (most significant bit first). The producer marks the first byte of a message, which restarts the remainder from all ones, and the last byte, after which the inverted remainder appears on the result port with a one-cycle completion pulse.

Top module: `crc32_lut_engine`

## Requirements
- R1: In reflected full-table mode, a one-byte message with in_first and in_last set yields on crc_o the standard reflected CRC-32 (initial value all ones, final inversion, polynomial 0xEDB88320) of that byte, for all 256 byte values.
- R2: A byte accepted with in_first high starts from an all-ones remainder, discarding whatever earlier bytes left behind; a byte accepted with in_first low continues from the current remainder, so a message may be split across several in_first/in_last spans.
- R3: crc_o is the bitwise inverse of the final remainder; it changes only in a cycle where done_o is high and otherwise holds its value, and done_o is high for exactly one cycle per message ending with in_last.
- R4: With LSB_FIRST=1 the byte is XORed into remainder bits 7..0 and the remainder shifts right using 0xEDB88320; the ASCII message "123456789" gives 0xCBF43926.
- R5: With LSB_FIRST=0 the byte is XORed into remainder bits 31..24 and the remainder shifts left using 0x04C11DB7; "123456789" gives 0xFC891918, and every one-byte message matches the bit-serial model in that order.
- R6: With SMALL_TABLE=0, in_ready stays high after reset, a byte is taken in every cycle that in_valid is high, and done_o rises in the cycle right after the cycle in which the last byte was taken.
- R7: With SMALL_TABLE=1, results equal those of the full-table mode for the same bytes; in_ready is low for exactly the one cycle following each accepted byte, and done_o rises two cycles after the cycle in which the last byte was taken.
- R8: While in_ready is low, in_valid, in_byte, in_first and in_last have no effect on the result or on done_o.
- R9: During and right after reset, done_o is low, crc_o is zero and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer offers a byte this cycle |
| in_ready | output | 1 | Engine takes the offered byte this cycle |
| in_byte | input | 8 | Data byte |
| in_first | input | 1 | Byte opens a message (preset remainder to all ones) |
| in_last | input | 1 | Byte closes a message (publish result) |
| crc_o | output | 32 | Inverted final remainder of the last completed message |
| done_o | output | 1 | One-cycle pulse when crc_o takes a new result |

## Verification
The bench sweeps every byte value as a one-byte message through all four combinations of table size and bit order and compares against a bit-serial division written in the bench; a wrong table entry, a byte merged into the wrong end of the remainder or a missing final inversion shows up there at once. Streams of growing length are pushed with in_valid held high, so the half-size engine must stall every second cycle while the bench presents a decoy byte with both flags set; an engine that sampled data while stalled would corrupt the result or pulse done early. Messages split across spans and messages restarted mid-stream catch an engine that ignores in_first or presets it on every byte, and the cycle count to done catches an off-by-one in the second nibble phase.

// File: rtl/crc32_lut_pkg.sv
package crc32_lut_pkg;

    localparam int CRC_W  = 32;
    localparam int BYTE_W = 8;

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Half-size mode walks each byte in two nibble phases
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } nib_phase_e;

    localparam crc_t CRC_PRESET = '1;

    function automatic crc_t bit_reverse(input crc_t v);
        crc_t r;
        for (int i = 0; i < CRC_W; i++) begin
            r[i] = v[CRC_W-1-i];
        end
        return r;
    endfunction

    // Correction word for one table index: run the bit-serial division
    // nbits times starting from the index placed at the outgoing end.
    function automatic crc_t table_entry(input int unsigned idx,
                                         input int unsigned nbits,
                                         input crc_t poly,
                                         input bit lsb_first);
        crc_t r;
        crc_t rpoly;
        rpoly = bit_reverse(poly);
        if (lsb_first) begin
            r = crc_t'(idx);
            for (int unsigned k = 0; k < nbits; k++) begin
                r = r[0] ? ((r >> 1) ^ rpoly) : (r >> 1);
            end
        end else begin
            r = crc_t'(idx) << (CRC_W - nbits);
            for (int unsigned k = 0; k < nbits; k++) begin
                r = r[CRC_W-1] ? ((r << 1) ^ poly) : (r << 1);
            end
        end
        return r;
    endfunction

    // Fold an input byte into the end of the remainder that leaves first
    function automatic crc_t merge_byte(input crc_t rem, input byte_t b,
                                        input bit lsb_first);
        crc_t ext;
        if (lsb_first) ext = {{(CRC_W-BYTE_W){1'b0}}, b};
        else           ext = {b, {(CRC_W-BYTE_W){1'b0}}};
        return rem ^ ext;
    endfunction

endpackage

// File: rtl/crc32_lut_rom.sv
module crc32_lut_rom
    import crc32_lut_pkg::*;
#(
    parameter int   IDX_W     = 8,
    parameter bit   LSB_FIRST = 1'b1,
    parameter crc_t POLY      = 32'h04C11DB7
) (
    input  logic [IDX_W-1:0] idx,
    output crc_t             entry
);
    localparam int DEPTH = 1 << IDX_W;

    crc_t rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        assign rom[g] = table_entry(g, IDX_W, POLY, LSB_FIRST);
    end

    assign entry = rom[idx];

endmodule

// File: rtl/crc32_lut_step.sv
module crc32_lut_step
    import crc32_lut_pkg::*;
#(
    parameter int   STEP_W    = 8,
    parameter bit   LSB_FIRST = 1'b1,
    parameter crc_t POLY      = 32'h04C11DB7
) (
    input  crc_t rem_i,
    output crc_t rem_o
);
    logic [STEP_W-1:0] idx;
    crc_t              corr;

    crc32_lut_rom #(
        .IDX_W     (STEP_W),
        .LSB_FIRST (LSB_FIRST),
        .POLY      (POLY)
    ) u_rom (
        .idx   (idx),
        .entry (corr)
    );

    if (LSB_FIRST) begin : g_refl
        assign idx   = rem_i[STEP_W-1:0];
        assign rem_o = (rem_i >> STEP_W) ^ corr;
    end else begin : g_norm
        assign idx   = rem_i[CRC_W-1 -: STEP_W];
        assign rem_o = (rem_i << STEP_W) ^ corr;
    end

endmodule

// File: rtl/crc32_lut_engine.sv
module crc32_lut_engine
    import crc32_lut_pkg::*;
#(
    parameter bit   SMALL_TABLE = 1'b0,
    parameter bit   LSB_FIRST   = 1'b1,
    parameter crc_t POLY        = 32'h04C11DB7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_byte,
    input  logic        in_first,
    input  logic        in_last,
    output logic [31:0] crc_o,
    output logic        done_o
);
    localparam int STEP_W = SMALL_TABLE ? (BYTE_W / 2) : BYTE_W;

    crc_t rem_q;
    crc_t crc_q;
    logic done_q;
    crc_t base;
    crc_t merged;
    crc_t step_in;
    crc_t step_out;
    logic accept;

    assign accept = in_valid && in_ready;
    assign base   = in_first ? CRC_PRESET : rem_q;
    assign merged = merge_byte(base, in_byte, LSB_FIRST);

    crc32_lut_step #(
        .STEP_W    (STEP_W),
        .LSB_FIRST (LSB_FIRST),
        .POLY      (POLY)
    ) u_step (
        .rem_i (step_in),
        .rem_o (step_out)
    );

    if (SMALL_TABLE) begin : g_half
        nib_phase_e phase_q;
        logic       fin_q;

        assign in_ready = (phase_q == PH_FIRST);
        assign step_in  = (phase_q == PH_SECOND) ? rem_q : merged;

        always_ff @(posedge clk) begin
            if (rst) begin
                phase_q <= PH_FIRST;
                fin_q   <= 1'b0;
                rem_q   <= CRC_PRESET;
                crc_q   <= '0;
                done_q  <= 1'b0;
            end else begin
                done_q <= 1'b0;
                if (phase_q == PH_SECOND) begin
                    rem_q   <= step_out;
                    phase_q <= PH_FIRST;
                    if (fin_q) begin
                        crc_q  <= ~step_out;
                        done_q <= 1'b1;
                    end
                end else if (accept) begin
                    rem_q   <= step_out;
                    fin_q   <= in_last;
                    phase_q <= PH_SECOND;
                end
            end
        end
    end else begin : g_full
        assign in_ready = 1'b1;
        assign step_in  = merged;

        always_ff @(posedge clk) begin
            if (rst) begin
                rem_q  <= CRC_PRESET;
                crc_q  <= '0;
                done_q <= 1'b0;
            end else begin
                done_q <= 1'b0;
                if (accept) begin
                    rem_q <= step_out;
                    if (in_last) begin
                        crc_q  <= ~step_out;
                        done_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign crc_o  = crc_q;
    assign done_o = done_q;

endmodule

// File: rtl/crc32_lut_engine_chk.sv
module crc32_lut_engine_chk #(
    parameter bit SMALL_TABLE = 1'b0
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        in_last,
    input logic [31:0] crc_o,
    input logic        done_o
);
    // R9: reset clears the completion pulse and the result
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (!done_o && crc_o == 32'h0));

    // R3: the result only moves together with the completion pulse
    a_r3_result_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(crc_o) |-> done_o);

    if (SMALL_TABLE) begin : g_half_chk
        // R7: one stall cycle after every accepted byte
        a_r7_ready_drop: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_ready) |=> !in_ready);

        // R7: the stall never lasts longer than one cycle
        a_r7_ready_back: assert property (@(posedge clk) disable iff (rst)
            !in_ready |=> in_ready);

        // R7: completion comes two cycles after the closing byte
        a_r7_done_lat: assert property (@(posedge clk) disable iff (rst)
            done_o |-> $past(in_valid && in_ready && in_last, 2));
    end else begin : g_full_chk
        // R6: completion comes one cycle after the closing byte
        a_r6_done_lat: assert property (@(posedge clk) disable iff (rst)
            done_o |-> $past(in_valid && in_ready && in_last));
    end

endmodule

bind crc32_lut_engine crc32_lut_engine_chk #(
    .SMALL_TABLE (SMALL_TABLE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_last  (in_last),
    .crc_o    (crc_o),
    .done_o   (done_o)
);

// File: tb/tb_crc32_lut_engine.sv
`timescale 1ns/1ps
module tb_crc32_lut_engine;

    localparam int NI = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        v   [NI];
    logic        f   [NI];
    logic        l   [NI];
    logic [7:0]  b   [NI];
    logic        rdy [NI];
    logic        dn  [NI];
    logic [31:0] crc [NI];

    // instance index: 0 reflected/full, 1 reflected/half, 2 straight/full, 3 straight/half
    localparam bit LSB_CFG  [NI] = '{1'b1, 1'b1, 1'b0, 1'b0};
    localparam bit HALF_CFG [NI] = '{1'b0, 1'b1, 1'b0, 1'b1};

    crc32_lut_engine #(.SMALL_TABLE(1'b0), .LSB_FIRST(1'b1)) dut (
        .clk(clk), .rst(rst), .in_valid(v[0]), .in_ready(rdy[0]), .in_byte(b[0]),
        .in_first(f[0]), .in_last(l[0]), .crc_o(crc[0]), .done_o(dn[0]));
    crc32_lut_engine #(.SMALL_TABLE(1'b1), .LSB_FIRST(1'b1)) dut_half (
        .clk(clk), .rst(rst), .in_valid(v[1]), .in_ready(rdy[1]), .in_byte(b[1]),
        .in_first(f[1]), .in_last(l[1]), .crc_o(crc[1]), .done_o(dn[1]));
    crc32_lut_engine #(.SMALL_TABLE(1'b0), .LSB_FIRST(1'b0)) dut_msb (
        .clk(clk), .rst(rst), .in_valid(v[2]), .in_ready(rdy[2]), .in_byte(b[2]),
        .in_first(f[2]), .in_last(l[2]), .crc_o(crc[2]), .done_o(dn[2]));
    crc32_lut_engine #(.SMALL_TABLE(1'b1), .LSB_FIRST(1'b0)) dut_msb_half (
        .clk(clk), .rst(rst), .in_valid(v[3]), .in_ready(rdy[3]), .in_byte(b[3]),
        .in_first(f[3]), .in_last(l[3]), .crc_o(crc[3]), .done_o(dn[3]));

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int done_cnt [NI];

    logic [7:0] msg [64];

    always @(negedge clk) begin
        for (int k = 0; k < NI; k++) begin
            if (!rst && dn[k]) done_cnt[k]++;
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Bit-serial division, independent of any table
    function automatic logic [31:0] model(input bit lsb, input int len);
        logic [31:0] r;
        logic fb;
        r = 32'hFFFF_FFFF;
        for (int i = 0; i < len; i++) begin
            for (int j = 0; j < 8; j++) begin
                if (lsb) begin
                    fb = r[0] ^ msg[i][j];
                    r  = r >> 1;
                    if (fb) r = r ^ 32'hEDB88320;
                end else begin
                    fb = r[31] ^ msg[i][7-j];
                    r  = r << 1;
                    if (fb) r = r ^ 32'h04C11DB7;
                end
            end
        end
        return ~r;
    endfunction

    // Push msg[0..len-1] into instance k; decoy bytes while stalled if junk
    task automatic run_msg(input int k, input int len, input bit first,
                           input bit last, input bit junk, input int gap,
                           output logic [31:0] res, output int lat,
                           output int iters);
        int i;
        i = 0;
        iters = 0;
        lat = 0;
        while (i < len) begin
            @(negedge clk);
            iters++;
            if (rdy[k]) begin
                v[k] = 1'b1;
                b[k] = msg[i];
                f[k] = first && (i == 0);
                l[k] = last && (i == len - 1);
                i++;
                if (gap > 0 && i < len) begin
                    @(negedge clk);
                    v[k] = 1'b0;
                    repeat (gap - 1) @(negedge clk);
                end
            end else begin
                v[k] = junk;
                b[k] = 8'h5A ^ 8'(i);
                f[k] = junk;
                l[k] = junk;
            end
        end
        @(negedge clk);
        v[k] = 1'b0;
        f[k] = 1'b0;
        l[k] = 1'b0;
        if (last) begin
            lat = 1;
            while (!dn[k] && lat < 10) begin
                @(negedge clk);
                lat++;
            end
        end
        res = crc[k];
    endtask

    task automatic load_check_string();
        for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] res;
        logic [31:0] held;
        int lat;
        int iters;
        int dc;
        for (int k = 0; k < NI; k++) begin
            v[k] = 1'b0; f[k] = 1'b0; l[k] = 1'b0; b[k] = 8'h00; done_cnt[k] = 0;
        end
        repeat (4) @(negedge clk);
        // R9: state while reset is held
        for (int k = 0; k < NI; k++) begin
            check(!dn[k] && crc[k] == 32'h0 && rdy[k], "R9 in reset", crc[k], 32'h0);
        end
        rst = 1'b0;
        @(negedge clk);
        for (int k = 0; k < NI; k++) begin
            check(!dn[k] && crc[k] == 32'h0, "R9 after reset", crc[k], 32'h0);
            check(rdy[k] == 1'b1, "R9 ready after reset", 32'(rdy[k]), 32'h1);
        end

        // R1 / R5 / R7: every one-byte message on every configuration
        for (int k = 0; k < NI; k++) begin
            for (int bv = 0; bv < 256; bv++) begin
                msg[0] = 8'(bv);
                run_msg(k, 1, 1'b1, 1'b1, 1'b0, 0, res, lat, iters);
                if (k == 0)      check(res == model(1'b1, 1), "R1 single byte", res, model(1'b1, 1));
                else if (k == 2) check(res == model(1'b0, 1), "R5 single byte", res, model(1'b0, 1));
                else             check(res == model(LSB_CFG[k], 1), "R7 single byte half", res, model(LSB_CFG[k], 1));
                if (HALF_CFG[k]) check(lat == 2, "R7 done latency", 32'(lat), 32'd2);
                else             check(lat == 1, "R6 done latency", 32'(lat), 32'd1);
            end
        end

        // R4 / R5: check string
        for (int k = 0; k < NI; k++) begin
            load_check_string();
            run_msg(k, 9, 1'b1, 1'b1, 1'b1, 0, res, lat, iters);
            if (LSB_CFG[k]) check(res == 32'hCBF43926, "R4 check string", res, 32'hCBF43926);
            else            check(res == 32'hFC891918, "R5 check string", res, 32'hFC891918);
        end

        // R6 / R7 / R8: streams with valid held high and decoys while stalled
        for (int k = 0; k < NI; k++) begin
            for (int len = 2; len <= 20; len++) begin
                for (int i = 0; i < len; i++) msg[i] = 8'((i * 37 + len * 11 + k * 5) ^ (i << 3));
                run_msg(k, len, 1'b1, 1'b1, 1'b1, 0, res, lat, iters);
                check(res == model(LSB_CFG[k], len), "R8 stream result", res, model(LSB_CFG[k], len));
                if (HALF_CFG[k]) check(iters == 2 * len - 1, "R7 stall pattern", 32'(iters), 32'(2 * len - 1));
                else             check(iters == len, "R6 one byte per cycle", 32'(iters), 32'(len));
            end
        end

        // R6: idle cycles between bytes
        for (int i = 0; i < 5; i++) msg[i] = 8'hC3 ^ 8'(i * 29);
        run_msg(0, 5, 1'b1, 1'b1, 1'b0, 2, res, lat, iters);
        check(res == model(1'b1, 5), "R6 gapped stream", res, model(1'b1, 5));

        // R2: restart mid-stream and split spans
        for (int k = 0; k < NI; k++) begin
            for (int i = 0; i < 6; i++) msg[i] = 8'hE7 - 8'(i);
            run_msg(k, 6, 1'b1, 1'b0, 1'b1, 0, res, lat, iters);
            load_check_string();
            run_msg(k, 9, 1'b1, 1'b1, 1'b0, 0, res, lat, iters);
            check(res == (LSB_CFG[k] ? 32'hCBF43926 : 32'hFC891918), "R2 restart preset",
                  res, LSB_CFG[k] ? 32'hCBF43926 : 32'hFC891918);
            run_msg(k, 4, 1'b1, 1'b0, 1'b1, 0, res, lat, iters);
            for (int i = 0; i < 5; i++) msg[i] = 8'h35 + 8'(i);
            run_msg(k, 5, 1'b0, 1'b1, 1'b1, 0, res, lat, iters);
            check(res == (LSB_CFG[k] ? 32'hCBF43926 : 32'hFC891918), "R2 split continue",
                  res, LSB_CFG[k] ? 32'hCBF43926 : 32'hFC891918);
        end

        // R3: result held across an open message, done pulses once
        for (int k = 0; k < NI; k++) begin
            held = crc[k];
            @(negedge clk);
            check(!dn[k], "R3 done is a pulse", 32'(dn[k]), 32'h0);
            dc = done_cnt[k];
            for (int i = 0; i < 7; i++) msg[i] = 8'(i * 71 + 3);
            run_msg(k, 7, 1'b1, 1'b0, 1'b1, 0, res, lat, iters);
            repeat (3) @(negedge clk);
            check(crc[k] == held, "R3 result held", crc[k], held);
            check(done_cnt[k] == dc, "R3 no done without last", 32'(done_cnt[k]), 32'(dc));
            run_msg(k, 7, 1'b1, 1'b1, 1'b1, 0, res, lat, iters);
            repeat (3) @(negedge clk);
            check(done_cnt[k] == dc + 1, "R3 single done pulse", 32'(done_cnt[k]), 32'(dc + 1));
            check(crc[k] == ~(~model(LSB_CFG[k], 7)), "R3 inverted result", crc[k], model(LSB_CFG[k], 7));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule